// File: doc/BRIEF.md
# D-Channel Byte Assembler and Serializer

This block serves the two-bit signalling channel of a time-division-multiplexed line interface. Each frame carries two signalling bits in consecutive bit periods. The bit index of the first of them, counted from the frame-sync bit, is programmable. The block collects these bits over a group of four frames into one 8-bit receive byte and reports it with a one-cycle strobe. In the same bit periods it shifts a host-supplied transmit byte onto the line, two bits per frame.

A mode input selects the bit order. In HDLC mode the line carries the least significant bit first. In unencoded mode it carries the most significant bit first, so the first frame's pair fills the top of the byte. The host writes transmit bytes into a one-entry holding register and acknowledges received bytes. Sticky flags record a missed acknowledge and a group that started with nothing to send. Frame generation, the other channels, flag detection, bit stuffing and CRC are handled elsewhere.

Top module: `dchan_codec`

## Requirements
- R1: The bit period in which `fsync` and `bit_tick` are both high has index 0, and each later `bit_tick` raises the index by one. Only the ticks with index `slot_ofs` and `slot_ofs`+1 carry signalling bits. `din` is ignored on all other ticks, and `slot_ofs` must not exceed the frame length minus two.
- R2: With `mode_i`=0 (HDLC order), the k-th signalling bit of a group (k=0..7) is stored in bit k of `rx_byte`. The two bits of frame f therefore fill bits 2f and 2f+1.
- R3: With `mode_i`=1 (unencoded order), the k-th signalling bit of a group is stored in bit 7-k. The first frame fills bits 7:6, the second 5:4, the third 3:2 and the fourth 1:0.
- R4: `rx_byte` takes the assembled byte and `rx_valid` is high for exactly one clock cycle. Both happen on the clock edge that samples the eighth signalling bit of the group. Out of reset `rx_valid` is 0.
- R5: If a byte completes while the previous one has not been acknowledged with `rx_ack`, the sticky flag `rx_overrun` is set. The newer byte replaces the older one in `rx_byte`.
- R6: On every signalling tick `dout` carries the next bit of the transmit byte. It goes bit 0 first with `mode_i`=0 and bit 7 first with `mode_i`=1, in the same order as reception. Outside signalling ticks `dout` is 1.
- R7: A `tx_load` pulse fills the holding register, and `tx_req` is high whenever that register is empty. The first signalling tick of each group takes the held byte and empties the register. If the register is empty at that tick, the group sends 8'hFF and the sticky flag `tx_underrun` is set.
- R8: A one-cycle `resync` returns the group position to the first frame, so the next signalling tick is frame 0, bit 0. Driving `en` low does the same, and it also clears both sticky flags and empties the holding register.
- R9: After `en` rises, no signalling tick occurs until the first `fsync` tick. Before that `din` is ignored and `dout` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Block enable; low holds the block idle and clears its flags |
| resync | input | 1 | Restart the four-frame group at its first frame |
| mode_i | input | 1 | Bit order: 0 HDLC (lsb first), 1 unencoded (msb first) |
| fsync | input | 1 | Frame sync; qualifies the bit tick that is bit 0 of a frame |
| bit_tick | input | 1 | One-cycle strobe per line bit period |
| slot_ofs | input | CNT_W | Bit index of the first signalling bit within the frame |
| din | input | 1 | Serial line data in, sampled on bit ticks |
| dout | output | 1 | Serial line data out, valid during bit ticks |
| rx_byte | output | 8 | Last assembled receive byte |
| rx_valid | output | 1 | One-cycle strobe: new byte in rx_byte |
| rx_ack | input | 1 | Host acknowledge of the pending receive byte |
| rx_overrun | output | 1 | Sticky: a byte completed before the previous one was acknowledged |
| tx_byte | input | 8 | Transmit byte to load |
| tx_load | input | 1 | Write tx_byte into the holding register |
| tx_req | output | 1 | Holding register empty, next byte wanted |
| tx_underrun | output | 1 | Sticky: a group started with the holding register empty |

## Verification
A group position that is off by one rotates the received byte by two bits, and a wrong order swap mirrors it. Either fault shows in `rx_byte` at the strobe that closes the group, at most four frames after the fault. A shift-register or selection fault on the transmit side shows at the very signalling tick where `dout` differs from the expected bit. A counter that drifts from the frame sync moves sampling off the programmed offset. That corrupts both directions within one frame, and idle ticks also stop reading as ones. The sweeps cover both orders, three offsets including the last legal one, and gapped bit ticks, so every bit position and every frame slot is compared.

// File: rtl/dch_pkg.sv
package dch_pkg;

  localparam int unsigned DCH_BYTE_W   = 8;
  localparam int unsigned DCH_PER_FRM  = 2;
  localparam int unsigned DCH_FRAMES   = DCH_BYTE_W / DCH_PER_FRM;
  localparam int unsigned DCH_POS_W    = $clog2(DCH_BYTE_W);

  typedef enum logic {
    DCH_LSB_FIRST = 1'b0,
    DCH_MSB_FIRST = 1'b1
  } dch_order_e;

  // Shift one received line bit into a partial byte.
  function automatic logic [DCH_BYTE_W-1:0] dch_push(
    input logic [DCH_BYTE_W-1:0] v,
    input logic                  b,
    input dch_order_e            o
  );
    return (o == DCH_MSB_FIRST) ? {v[DCH_BYTE_W-2:0], b} : {b, v[DCH_BYTE_W-1:1]};
  endfunction

  // Bit that goes on the line next for a given order.
  function automatic logic dch_head(
    input logic [DCH_BYTE_W-1:0] v,
    input dch_order_e            o
  );
    return (o == DCH_MSB_FIRST) ? v[DCH_BYTE_W-1] : v[0];
  endfunction

  // Drop the bit just sent, filling with ones.
  function automatic logic [DCH_BYTE_W-1:0] dch_pop(
    input logic [DCH_BYTE_W-1:0] v,
    input dch_order_e            o
  );
    return (o == DCH_MSB_FIRST) ? {v[DCH_BYTE_W-2:0], 1'b1} : {1'b1, v[DCH_BYTE_W-1:1]};
  endfunction

endpackage

// File: rtl/dch_slot_timer.sv
module dch_slot_timer
  import dch_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             resync,
  input  logic             fsync,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] slot_ofs,
  output logic             slot_tick,
  output logic             grp_first,
  output logic             grp_last
);

  localparam logic [CNT_W-1:0]     IDX_MAX = {CNT_W{1'b1}};
  localparam logic [DCH_POS_W-1:0] POS_END = DCH_POS_W'(DCH_BYTE_W - 1);

  logic [CNT_W-1:0]     bit_q, bit_d;
  logic                 sync_q, sync_d;
  logic [DCH_POS_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0]     idx;
  logic                 in_win;

  always_comb begin
    if (fsync)                idx = '0;
    else if (bit_q == IDX_MAX) idx = bit_q;
    else                      idx = bit_q + 1'b1;
  end

  assign in_win    = (idx == slot_ofs) ||
                     ({1'b0, idx} == ({1'b0, slot_ofs} + 1'b1));
  assign slot_tick = en && bit_tick && (sync_q || fsync) && in_win;
  assign grp_first = (pos_q == '0);
  assign grp_last  = (pos_q == POS_END);

  always_comb begin
    bit_d  = bit_q;
    sync_d = sync_q;
    pos_d  = pos_q;
    if (!en) begin
      bit_d  = '0;
      sync_d = 1'b0;
    end else if (bit_tick) begin
      bit_d = idx;
      if (fsync) sync_d = 1'b1;
    end
    if (!en || resync)  pos_d = '0;
    else if (slot_tick) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      sync_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      bit_q  <= bit_d;
      sync_q <= sync_d;
      pos_q  <= pos_d;
    end
  end

  assert_resync_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resync || !en) |=> (pos_q == '0));

  assert_sync_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> $past(fsync && bit_tick && en));

endmodule

// File: rtl/dch_rx.sv
module dch_rx
  import dch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  dch_order_e            order,
  input  logic                  slot_tick,
  input  logic                  grp_last,
  input  logic                  din,
  input  logic                  ack,
  output logic [DCH_BYTE_W-1:0] rx_byte,
  output logic                  rx_valid,
  output logic                  rx_overrun
);

  logic [DCH_BYTE_W-1:0] sh_q, sh_d, nxt_sh, byte_q, byte_d;
  logic                  vld_q, vld_d, pend_q, pend_d, ovr_q, ovr_d, done;

  assign nxt_sh = dch_push(sh_q, din, order);
  assign done   = slot_tick && grp_last;

  always_comb begin
    sh_d   = slot_tick ? nxt_sh : sh_q;
    byte_d = done ? nxt_sh : byte_q;
    vld_d  = done;
    pend_d = pend_q;
    ovr_d  = ovr_q;
    if (!en) begin
      pend_d = 1'b0;
      ovr_d  = 1'b0;
    end else begin
      if (done && pend_q && !ack) ovr_d = 1'b1;
      if (done)     pend_d = 1'b1;
      else if (ack) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_byte    = byte_q;
  assign rx_valid   = vld_q;
  assign rx_overrun = ovr_q;

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && en) |=> rx_overrun);

endmodule

// File: rtl/dch_tx.sv
module dch_tx
  import dch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  dch_order_e            order,
  input  logic                  slot_tick,
  input  logic                  grp_first,
  input  logic                  ld,
  input  logic [DCH_BYTE_W-1:0] ld_byte,
  output logic                  dout,
  output logic                  req,
  output logic                  underrun
);

  logic [DCH_BYTE_W-1:0] hold_q, hold_d, sh_q, sh_d, cur;
  logic                  full_q, full_d, und_q, und_d, take;

  assign take = slot_tick && grp_first;

  always_comb begin
    if (grp_first) cur = full_q ? hold_q : '1;
    else           cur = sh_q;
  end

  assign dout = slot_tick ? dch_head(cur, order) : 1'b1;

  always_comb begin
    sh_d   = slot_tick ? dch_pop(cur, order) : sh_q;
    hold_d = ld ? ld_byte : hold_q;
    full_d = full_q;
    und_d  = und_q;
    if (!en) begin
      full_d = 1'b0;
      und_d  = 1'b0;
    end else begin
      if (take && !full_q) und_d = 1'b1;
      if (ld)        full_d = 1'b1;
      else if (take) full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '1;
      full_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      full_q <= full_d;
      und_q  <= und_d;
    end
  end

  assign req      = !full_q;
  assign underrun = und_q;

  assert_underrun_on_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && take && req) |=> underrun);

  assert_load_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ld) |=> !req);

endmodule

// File: rtl/dchan_codec.sv
module dchan_codec
  import dch_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             resync,
  input  logic             mode_i,
  input  logic             fsync,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] slot_ofs,
  input  logic             din,
  output logic             dout,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  input  logic             rx_ack,
  output logic             rx_overrun,
  input  logic [7:0]       tx_byte,
  input  logic             tx_load,
  output logic             tx_req,
  output logic             tx_underrun
);

  dch_order_e order;
  logic       slot_tick, grp_first, grp_last;

  assign order = dch_order_e'(mode_i);

  dch_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .resync    (resync),
    .fsync     (fsync),
    .bit_tick  (bit_tick),
    .slot_ofs  (slot_ofs),
    .slot_tick (slot_tick),
    .grp_first (grp_first),
    .grp_last  (grp_last)
  );

  dch_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .order      (order),
    .slot_tick  (slot_tick),
    .grp_last   (grp_last),
    .din        (din),
    .ack        (rx_ack),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .rx_overrun (rx_overrun)
  );

  dch_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .order     (order),
    .slot_tick (slot_tick),
    .grp_first (grp_first),
    .ld        (tx_load),
    .ld_byte   (tx_byte),
    .dout      (dout),
    .req       (tx_req),
    .underrun  (tx_underrun)
  );

  assert_idle_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |-> dout);

endmodule

// File: tb/tb_dchan_codec.sv
module tb_dchan_codec;

  localparam int CNT_W = 4;
  localparam int FLEN  = 12;

  logic clk = 1'b0;
  logic rst_n, en, resync, mode_i, fsync, bit_tick, din, rx_ack, tx_load;
  logic [CNT_W-1:0] slot_ofs;
  logic [7:0] tx_byte, rx_byte;
  logic dout, rx_valid, rx_overrun, tx_req, tx_underrun;

  always #2.5 clk = ~clk;

  dchan_codec #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .resync(resync), .mode_i(mode_i),
    .fsync(fsync), .bit_tick(bit_tick), .slot_ofs(slot_ofs), .din(din),
    .dout(dout), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .rx_overrun(rx_overrun), .tx_byte(tx_byte), .tx_load(tx_load),
    .tx_req(tx_req), .tx_underrun(tx_underrun)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int vcnt  = 0;
  int gap   = 0;
  logic [7:0] vbyte = 8'h00;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      vcnt  <= vcnt + 1;
      vbyte <= rx_byte;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bitof(input logic [7:0] v, input int k, input logic m);
    return m ? v[7-k] : v[k];
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_tick = 1'b0; fsync = 1'b0; din = 1'($urandom);
      rx_ack = 1'b0; tx_load = 1'b0; resync = 1'b0;
    end
  endtask

  // One frame: signalling pair b0,b1 in, t0,t1 expected on dout.
  task automatic frame(input logic b0, input logic b1, input logic t0, input logic t1,
                       input bit chk_out);
    for (int i = 0; i < FLEN; i++) begin
      logic e;
      @(negedge clk);
      fsync    = (i == 0);
      bit_tick = 1'b1;
      if (i == int'(slot_ofs))          begin din = b0; e = t0; end
      else if (i == int'(slot_ofs) + 1) begin din = b1; e = t1; end
      else                              begin din = 1'($urandom); e = 1'b1; end
      #1;
      if (chk_out) chk("R6 dout", 32'(dout), 32'(e));
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic group(input logic [7:0] rv, input logic [7:0] tv);
    for (int f = 0; f < 4; f++)
      frame(bitof(rv, 2*f, mode_i), bitof(rv, 2*f+1, mode_i),
            bitof(tv, 2*f, mode_i), bitof(tv, 2*f+1, mode_i), 1'b1);
    idle(2);
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); tx_byte = v; tx_load = 1'b1; bit_tick = 1'b0; fsync = 1'b0;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v0;
    rst_n = 1'b0; en = 1'b0; resync = 1'b0; mode_i = 1'b0; fsync = 1'b0;
    bit_tick = 1'b0; din = 1'b0; rx_ack = 1'b0; tx_load = 1'b0;
    slot_ofs = '0; tx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R4 reset rx_valid", 32'(rx_valid), 0);
    chk("R7 reset tx_req", 32'(tx_req), 1);
    chk("R5 reset rx_overrun", 32'(rx_overrun), 0);
    chk("R7 reset tx_underrun", 32'(tx_underrun), 0);
    chk("R6 reset dout", 32'(dout), 1);

    // R9: ticks before first frame sync carry nothing
    en = 1'b1; slot_ofs = 4'd2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_tick = 1'b1; fsync = 1'b0; din = 1'b0; #1;
      chk("R9 dout before sync", 32'(dout), 1);
    end
    // first group with nothing loaded: underrun, all ones sent (R7)
    v0 = vcnt;
    group(8'h5A, 8'hFF);
    chk("R9 byte after sync", 32'(vbyte), 32'h5A);
    chk("R4 one strobe", 32'(vcnt - v0), 1);
    chk("R7 underrun set", 32'(tx_underrun), 1);
    chk("R7 req while empty", 32'(tx_req), 1);
    ack();

    // R8: enable low clears flags
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1; #1;
    chk("R8 underrun cleared", 32'(tx_underrun), 0);
    chk("R8 overrun cleared", 32'(rx_overrun), 0);

    // sweep orders, offsets and gaps (R1 R2 R3 R4 R6 R7)
    for (int m = 0; m < 2; m++) begin
      for (int oi = 0; oi < 3; oi++) begin
        mode_i = 1'(m);
        gap = m;
        slot_ofs = (oi == 0) ? 4'd0 : (oi == 1) ? 4'd5 : 4'(FLEN - 2);
        @(negedge clk); resync = 1'b1;
        @(negedge clk); resync = 1'b0;
        for (int j = 0; j < 3; j++) begin
          logic [7:0] rv, tv;
          rv = 8'((j * 73 + oi * 29 + m * 101 + 17) & 255);
          tv = rv ^ 8'hC3;
          load(tv);
          chk("R7 req after load", 32'(tx_req), 0);
          v0 = vcnt;
          group(rv, tv);
          chk("R4 strobe count", 32'(vcnt - v0), 1);
          chk(m ? "R3 msb-first byte" : "R2 lsb-first byte", 32'(vbyte), 32'(rv));
          chk("R1 rx_byte held", 32'(rx_byte), 32'(rv));
          chk("R7 req after take", 32'(tx_req), 1);
          chk("R7 no underrun", 32'(tx_underrun), 0);
          ack();
        end
      end
    end

    // R3 field placement: only first frame's pair set in msb-first order
    mode_i = 1'b1; gap = 0; slot_ofs = 4'd3;
    load(8'hFF);
    frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    frame(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    frame(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    frame(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(2);
    chk("R3 frame0 in bits 7:6", 32'(vbyte), 32'hC1);
    ack();
    // R2 same pattern lsb-first
    mode_i = 1'b0;
    load(8'hFF);
    frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    frame(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    frame(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    frame(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(2);
    chk("R2 frame0 in bits 1:0", 32'(vbyte), 32'h83);
    ack();

    // R5 overrun
    load(8'h11); group(8'h11, 8'h11);
    load(8'h22); group(8'h22, 8'h22);
    chk("R5 overrun set", 32'(rx_overrun), 1);
    chk("R5 newer byte kept", 32'(rx_byte), 32'h22);
    ack();
    load(8'h33); group(8'h33, 8'h33);
    chk("R5 overrun sticky", 32'(rx_overrun), 1);
    ack();

    // R8 resync mid-group
    load(8'h44);
    frame(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    frame(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk); bit_tick = 1'b0; resync = 1'b1;
    @(negedge clk); resync = 1'b0;
    v0 = vcnt;
    load(8'h96);
    group(8'h69, 8'h96);
    chk("R8 resync realigned", 32'(vbyte), 32'h69);
    chk("R8 single strobe", 32'(vcnt - v0), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule